// File: doc/BRIEF.md
# ROM Signature Self-Test Controller

This block tests a read-only memory without software reading it word by word. Software programs it over a small register bus. It enables the engine with a two-bit activate field, picks the operating modes, loads a 64-bit expected signature as two 32-bit halves, sets an inclusive address range, and sets the start bit. The engine then reads each ROM address in the range, one per cycle, in ascending order. It folds every returned word into a 64-bit multiple-input signature register (MISR). When the range is finished, the engine compares the signature with the expected value if comparison mode is on. It records pass or fail, raises an interrupt and keeps the signature available for readback.

The ROM port has a fixed read latency of one cycle and never stalls. The engine gives no back-pressure and needs none. A word the ROM returns is taken in the cycle after its read strobe, with no handshake. The register bus is a single-cycle write strobe with combinational read data. An exit command stops a run in progress, clears the result and sends the engine back to idle, ready for the next setting.

Top module: `rom_sig_bist`

## Requirements
- R1: Register writes are accepted only while the activate field (bits 1:0 at word address 0) reads 2'b01. Otherwise every write to any other address has no effect and every other address reads 0. The activate field itself is always writable.
- R2: The expected signature (low half at address 4, high half at address 5), the range start (address 6), the range end (address 7) and the loop count (address 2) can be written only while the configuration bit (bit 4 of the mode register at address 1) is set.
- R3: Writing 1 to bit 0 of the start register (address 3) launches a test only when the engine is active, is idle and has signature mode (mode bit 8) set. A start write during a run is ignored. Reading address 3 returns the busy flag in bit 0.
- R4: A test asserts the ROM read strobe for exactly one cycle per address, for every address from the range start to the range end inclusive, in ascending order and in consecutive cycles.
- R5: A start clears the MISR to zero. On each cycle after a read strobe, the MISR becomes {m[62:0],0} XOR (m[63] ? 64'h1B : 0) XOR the ROM word. In every other cycle it holds its value.
- R6: The signature reads back at addresses 8 (low half) and 9 (high half). For a range of N words, the interrupt rises N+2 cycles after the clock edge that takes the start write.
- R7: Bit 0 of the fail register (address 10) is set at completion only when comparison mode (mode bit 9) is set and the signature differs from the expected value. A start clears it.
- R8: Once raised, the interrupt (output irq, bit 0 of address 11) stays high until software writes 1 to bit 0 of address 11. Writing 0 there has no effect.
- R9: Writing 1 to bit 0 of the exit register (address 12) stops any run and clears the busy flag, the fail bit, the interrupt and the signature.
- R10: If the range end is below the range start, a start performs no ROM reads. The signature stays zero and the interrupt rises 1 cycle after the start edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe, taken at the rising edge |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| rom_re | output | 1 | ROM read strobe |
| rom_addr | output | AW (10) | ROM read address |
| rom_rdata | input | 64 | ROM data, valid the cycle after rom_re |
| irq | output | 1 | Test-complete interrupt, held until cleared |

## Verification
Register writes take effect at the edge that samples the strobe. Read data is combinational, so the bench checks each readback in the same cycle it drives the address. The bench counts cycles from the edge that takes the start write to the rising interrupt and expects N+2 for a range of N words, or 1 for an empty range. This holds because the last word reaches the MISR one edge after its strobe and the compare takes one further edge. A monitor at each rising edge compares every ROM strobe against the next expected address and counts the strobes. Signature, fail and exit results are read only after the interrupt or after the exit write has been taken, always away from the clock edge.

// File: rtl/rsb_pkg.sv
package rsb_pkg;

  typedef enum logic [3:0] {
    RA_ACT    = 4'd0,
    RA_MODE   = 4'd1,
    RA_LOOP   = 4'd2,
    RA_START  = 4'd3,
    RA_EXP_LO = 4'd4,
    RA_EXP_HI = 4'd5,
    RA_RNG_LO = 4'd6,
    RA_RNG_HI = 4'd7,
    RA_SIG_LO = 4'd8,
    RA_SIG_HI = 4'd9,
    RA_FAIL   = 4'd10,
    RA_IRQ    = 4'd11,
    RA_EXIT   = 4'd12
  } reg_addr_e;

  localparam int MODE_CFG_BIT = 4;
  localparam int MODE_SIG_BIT = 8;
  localparam int MODE_CMP_BIT = 9;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_RUN,
    SQ_DRAIN,
    SQ_FINISH
  } seq_state_e;

endpackage

// File: rtl/rsb_misr.sv
module rsb_misr #(
  parameter int          W    = 64,
  parameter logic [W-1:0] TAPS = 64'h1B
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         vld,
  input  logic [W-1:0] din,
  output logic [W-1:0] sig
);

  logic [W-1:0] nxt;

  generate
    for (genvar i = 0; i < W; i++) begin : g_bit
      if (i == 0) begin : g_lsb
        assign nxt[i] = (TAPS[i] & sig[W-1]) ^ din[i];
      end else begin : g_up
        assign nxt[i] = sig[i-1] ^ (TAPS[i] & sig[W-1]) ^ din[i];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sig <= '0;
    else if (clear) sig <= '0;
    else if (vld)   sig <= nxt;
  end

  AST_SEED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (sig == '0)); // R5
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !vld) |=> $stable(sig)); // R5

endmodule

// File: rtl/rsb_seq.sv
module rsb_seq
  import rsb_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          abort,
  input  logic [AW-1:0] lo,
  input  logic [AW-1:0] hi,
  output logic          rom_re,
  output logic [AW-1:0] rom_addr,
  output logic          data_vld,
  output logic          busy,
  output logic          done
);

  seq_state_e   state;
  logic [AW-1:0] cur;

  assign rom_re   = (state == SQ_RUN);
  assign rom_addr = cur;
  assign busy     = (state != SQ_IDLE);
  assign done     = (state == SQ_FINISH) && !abort;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= SQ_IDLE;
      cur      <= '0;
      data_vld <= 1'b0;
    end else begin
      data_vld <= rom_re && !abort;
      if (abort) begin
        state <= SQ_IDLE;
      end else begin
        unique case (state)
          SQ_IDLE: begin
            if (start) begin
              cur   <= lo;
              state <= (hi < lo) ? SQ_FINISH : SQ_RUN;
            end
          end
          SQ_RUN: begin
            if (cur == hi) state <= SQ_DRAIN;
            else           cur   <= cur + 1'b1;
          end
          SQ_DRAIN:  state <= SQ_FINISH;
          SQ_FINISH: state <= SQ_IDLE;
          default:   state <= SQ_IDLE;
        endcase
      end
    end
  end

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_re && (rom_addr != hi) && !abort) |=>
      (rom_re && (rom_addr == $past(rom_addr) + 1'b1))); // R4
  AST_LAST_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_re && (rom_addr == hi) && !abort) |=> !rom_re); // R4
  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!busy && !rom_re)); // R9

endmodule

// File: rtl/rsb_regs.sv
module rsb_regs
  import rsb_pkg::*;
#(
  parameter int AW = 10,
  parameter int RW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [3:0]      addr,
  input  logic [RW-1:0]   wdata,
  output logic [RW-1:0]   rdata,
  input  logic            busy,
  input  logic            done,
  input  logic [2*RW-1:0] sig,
  output logic            start_pulse,
  output logic            exit_pulse,
  output logic [AW-1:0]   lo,
  output logic [AW-1:0]   hi,
  output logic            irq
);

  logic [1:0]      act_q;
  logic [RW-1:0]   mode_q;
  logic [RW-1:0]   loop_q;
  logic [2*RW-1:0] exp_q;
  logic            fail_q;
  logic            irq_q;
  logic            active, wr_ok, cfg_ok, irq_clr;

  assign active  = (act_q == 2'b01);
  assign wr_ok   = we && active;
  assign cfg_ok  = wr_ok && mode_q[MODE_CFG_BIT];
  assign irq_clr = wr_ok && (addr == RA_IRQ) && wdata[0];

  assign start_pulse = wr_ok && (addr == RA_START) && wdata[0]
                       && mode_q[MODE_SIG_BIT] && !busy;
  assign exit_pulse  = wr_ok && (addr == RA_EXIT) && wdata[0];
  assign irq = irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= '0;
      mode_q <= '0;
      loop_q <= '0;
      exp_q  <= '0;
      lo     <= '0;
      hi     <= '0;
    end else begin
      if (we && (addr == RA_ACT)) act_q <= wdata[1:0];
      if (wr_ok && (addr == RA_MODE)) mode_q <= wdata;
      if (cfg_ok) begin
        unique case (addr)
          RA_LOOP:   loop_q         <= wdata;
          RA_EXP_LO: exp_q[RW-1:0]  <= wdata;
          RA_EXP_HI: exp_q[2*RW-1:RW] <= wdata;
          RA_RNG_LO: lo             <= wdata[AW-1:0];
          RA_RNG_HI: hi             <= wdata[AW-1:0];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail_q <= 1'b0;
      irq_q  <= 1'b0;
    end else if (exit_pulse) begin
      fail_q <= 1'b0;
      irq_q  <= 1'b0;
    end else if (done) begin
      fail_q <= mode_q[MODE_CMP_BIT] && (sig != exp_q);
      irq_q  <= 1'b1;
    end else begin
      if (start_pulse) fail_q <= 1'b0;
      if (irq_clr)     irq_q  <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == RA_ACT) begin
      rdata[1:0] = act_q;
    end else if (active) begin
      unique case (addr)
        RA_MODE:   rdata = mode_q;
        RA_LOOP:   rdata = loop_q;
        RA_START:  rdata[0] = busy;
        RA_EXP_LO: rdata = exp_q[RW-1:0];
        RA_EXP_HI: rdata = exp_q[2*RW-1:RW];
        RA_RNG_LO: rdata[AW-1:0] = lo;
        RA_RNG_HI: rdata[AW-1:0] = hi;
        RA_SIG_LO: rdata = sig[RW-1:0];
        RA_SIG_HI: rdata = sig[2*RW-1:RW];
        RA_FAIL:   rdata[0] = fail_q;
        RA_IRQ:    rdata[0] = irq_q;
        default:   rdata = '0;
      endcase
    end
  end

  AST_INACTIVE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !(we && (addr == RA_ACT))) |=>
      ($stable(mode_q) && $stable(exp_q) && $stable(lo) && $stable(hi))); // R1
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !exit_pulse && !irq_clr) |=> irq_q); // R8
  AST_FAIL_NEEDS_CMP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail_q) |-> ($past(mode_q[MODE_CMP_BIT]) && $past(done))); // R7

endmodule

// File: rtl/rom_sig_bist.sv
module rom_sig_bist
  import rsb_pkg::*;
#(
  parameter int AW = 10,
  parameter int RW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_we,
  input  logic [3:0]      reg_addr,
  input  logic [RW-1:0]   reg_wdata,
  output logic [RW-1:0]   reg_rdata,
  output logic            rom_re,
  output logic [AW-1:0]   rom_addr,
  input  logic [2*RW-1:0] rom_rdata,
  output logic            irq
);

  localparam int SW = 2 * RW;
  localparam logic [SW-1:0] MISR_TAPS = SW'(64'h1B);

  logic          start_pulse, exit_pulse, busy, done, data_vld;
  logic [AW-1:0] lo, hi;
  logic [SW-1:0] sig;

  rsb_regs #(.AW(AW), .RW(RW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .busy(busy), .done(done),
    .sig(sig), .start_pulse(start_pulse), .exit_pulse(exit_pulse),
    .lo(lo), .hi(hi), .irq(irq)
  );

  rsb_seq #(.AW(AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start_pulse), .abort(exit_pulse),
    .lo(lo), .hi(hi), .rom_re(rom_re), .rom_addr(rom_addr),
    .data_vld(data_vld), .busy(busy), .done(done)
  );

  rsb_misr #(.W(SW), .TAPS(MISR_TAPS)) u_misr (
    .clk(clk), .rst_n(rst_n), .clear(start_pulse || exit_pulse),
    .vld(data_vld), .din(rom_rdata), .sig(sig)
  );

  AST_START_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    (start_pulse && (hi >= lo)) |=> (rom_re && (rom_addr == $past(lo)))); // R4
  AST_EMPTY_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (start_pulse && (hi < lo)) |=> (!rom_re && done)); // R10

endmodule

// File: tb/rom_sig_bist_tb.sv
module rom_sig_bist_tb;

  localparam int AW = 10;
  localparam int RW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_we = 1'b0;
  logic [3:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          rom_re;
  logic [AW-1:0] rom_addr;
  logic [63:0]   rom_rdata;
  logic          irq;

  always #4 clk = ~clk;

  rom_sig_bist #(.AW(AW), .RW(RW)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rom_re(rom_re),
    .rom_addr(rom_addr), .rom_rdata(rom_rdata), .irq(irq)
  );

  function automatic logic [63:0] rom_word(input logic [AW-1:0] a);
    logic [31:0] x;
    x = {22'd0, a};
    return {(x * 32'h9E3779B9) ^ 32'h5A5A0000, (~x) * 32'h85EBCA6B};
  endfunction

  function automatic logic [63:0] mstep(input logic [63:0] m, input logic [63:0] d);
    return {m[62:0], 1'b0} ^ (m[63] ? 64'h1B : 64'h0) ^ d;
  endfunction

  function automatic logic [63:0] model_sig(input int lo, input int hi);
    logic [63:0] m;
    m = '0;
    for (int a = lo; a <= hi; a++) m = mstep(m, rom_word(AW'(a)));
    return m;
  endfunction

  always_ff @(posedge clk) rom_rdata <= rom_word(rom_addr);

  int n_chk = 0;
  int n_fail = 0;
  int rd_cnt = 0;
  int addr_err = 0;
  logic [AW-1:0] exp_addr = '0;
  bit done_flag = 0;

  always @(posedge clk) begin
    if (rom_re) begin
      rd_cnt = rd_cnt + 1;
      if (rom_addr != exp_addr) addr_err = addr_err + 1;
      exp_addr = exp_addr + 1'b1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_irq(output int cyc);
    cyc = 0;
    while (!irq && cyc < 3000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic setup(input int lo, input int hi, input logic [63:0] expv, input bit cmp);
    wr(4'd1, 32'h110 | (cmp ? 32'h200 : 32'h0));
    wr(4'd2, 32'd0);
    wr(4'd4, expv[31:0]);
    wr(4'd5, expv[63:32]);
    wr(4'd6, 32'(lo));
    wr(4'd7, 32'(hi));
    rd_cnt = 0; addr_err = 0; exp_addr = AW'(lo);
  endtask

  // {lo, hi, bad expected, compare enable}
  localparam logic [21:0] VECS [0:5] = '{
    {10'd0,    10'd15,   1'b0, 1'b1},
    {10'd0,    10'd15,   1'b1, 1'b1},
    {10'd100,  10'd100,  1'b1, 1'b1},
    {10'd5,    10'd60,   1'b1, 1'b0},
    {10'd1020, 10'd1023, 1'b0, 1'b1},
    {10'd200,  10'd263,  1'b1, 1'b1}
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, d2;
    logic [63:0] m, e;
    int cyc, lo, hi, nw;
    bit bad, cmp;

    repeat (3) @(negedge clk);
    // reset state
    chk(irq == 1'b0, "R8", "irq after reset", 64'(irq), 0);
    chk(rom_re == 1'b0, "R4", "rom_re after reset", 64'(rom_re), 0);
    rst_n = 1'b1;
    rd(4'd0, d);
    chk(d == 0, "R1", "activate after reset", 64'(d), 0);

    // R1: inactive writes dropped, reads zero
    wr(4'd1, 32'h310);
    wr(4'd4, 32'hDEAD);
    wr(4'd0, 32'h3);
    rd(4'd1, d);
    chk(d == 0, "R1", "mode read while activate=3", 64'(d), 0);
    wr(4'd0, 32'h1);
    rd(4'd1, d);
    chk(d == 0, "R1", "mode write while inactive", 64'(d), 0);
    rd(4'd4, d);
    chk(d == 0, "R1", "expected write while inactive", 64'(d), 0);

    // R2: config bit gates config writes
    wr(4'd1, 32'h100);
    wr(4'd4, 32'h1234);
    rd(4'd4, d);
    chk(d == 0, "R2", "expected write without config bit", 64'(d), 0);
    wr(4'd1, 32'h110);
    wr(4'd4, 32'h1234);
    rd(4'd4, d);
    chk(d == 32'h1234, "R2", "expected write with config bit", 64'(d), 32'h1234);

    // vector table walk: R4 R5 R6 R7 R8
    for (int v = 0; v < 6; v++) begin
      lo  = int'(VECS[v][21:12]);
      hi  = int'(VECS[v][11:2]);
      bad = VECS[v][1];
      cmp = VECS[v][0];
      nw  = hi - lo + 1;
      m   = model_sig(lo, hi);
      e   = bad ? (m ^ 64'h1) : m;
      setup(lo, hi, e, cmp);
      wr(4'd3, 32'h1);
      wait_irq(cyc);
      chk(cyc == nw + 2, "R6", "interrupt latency", 64'(cyc), 64'(nw + 2));
      chk(rd_cnt == nw, "R4", "read count", 64'(rd_cnt), 64'(nw));
      chk(addr_err == 0, "R4", "address order errors", 64'(addr_err), 0);
      rd(4'd8, d); rd(4'd9, d2);
      chk({d2, d} == m, "R5", "signature", {d2, d}, m);
      rd(4'd10, d);
      chk(d[0] == (bad && cmp), "R7", "fail bit", 64'(d[0]), 64'(bad && cmp));
      wr(4'd11, 32'h0);
      chk(irq == 1'b1, "R8", "irq after writing 0", 64'(irq), 1);
      wr(4'd11, 32'h1);
      chk(irq == 1'b0, "R8", "irq after writing 1", 64'(irq), 0);
    end

    // R10: empty range
    setup(10, 5, 64'h0, 1'b1);
    wr(4'd3, 32'h1);
    wait_irq(cyc);
    chk(cyc == 1, "R10", "empty range latency", 64'(cyc), 1);
    chk(rd_cnt == 0, "R10", "empty range reads", 64'(rd_cnt), 0);
    rd(4'd8, d); rd(4'd9, d2);
    chk({d2, d} == 0, "R10", "empty range signature", {d2, d}, 0);
    wr(4'd11, 32'h1);

    // R3: start while running ignored
    m = model_sig(0, 40);
    setup(0, 40, m, 1'b1);
    wr(4'd3, 32'h1);
    rd(4'd3, d);
    chk(d[0] == 1'b1, "R3", "busy during run", 64'(d[0]), 1);
    wr(4'd3, 32'h1);
    wait_irq(cyc);
    chk(rd_cnt == 41, "R3", "reads with second start", 64'(rd_cnt), 41);
    rd(4'd8, d); rd(4'd9, d2);
    chk({d2, d} == m, "R3", "signature with second start", {d2, d}, m);
    wr(4'd11, 32'h1);

    // R3: start without signature mode ignored
    setup(0, 3, 64'h0, 1'b1);
    wr(4'd1, 32'h010);
    wr(4'd3, 32'h1);
    repeat (8) @(negedge clk);
    chk(rd_cnt == 0, "R3", "reads without signature mode", 64'(rd_cnt), 0);
    chk(irq == 1'b0, "R3", "irq without signature mode", 64'(irq), 0);

    // R9: exit after failing run
    setup(0, 7, 64'h0, 1'b1);
    wr(4'd3, 32'h1);
    wait_irq(cyc);
    rd(4'd10, d);
    chk(d[0] == 1'b1, "R7", "fail before exit", 64'(d[0]), 1);
    wr(4'd12, 32'h1);
    rd(4'd10, d);
    chk(d[0] == 1'b0, "R9", "fail after exit", 64'(d[0]), 0);
    chk(irq == 1'b0, "R9", "irq after exit", 64'(irq), 0);
    rd(4'd8, d); rd(4'd9, d2);
    chk({d2, d} == 0, "R9", "signature after exit", {d2, d}, 0);

    // R9: exit mid-run
    setup(0, 200, 64'h0, 1'b1);
    wr(4'd3, 32'h1);
    repeat (4) @(negedge clk);
    wr(4'd12, 32'h1);
    rd(4'd3, d);
    chk(d[0] == 1'b0, "R9", "busy after exit", 64'(d[0]), 0);
    chk(rom_re == 1'b0, "R9", "rom_re after exit", 64'(rom_re), 0);
    repeat (10) @(negedge clk);
    chk(irq == 1'b0, "R9", "no irq after aborted run", 64'(irq), 0);
    chk(rd_cnt < 201, "R9", "reads stopped", 64'(rd_cnt), 200);

    done_flag = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule